// File: doc/BRIEF.md
# Packet Data Port

This block gives a host byte-wide access to packet page memory. The host loads a 16-bit pointer and then moves bytes through a four-byte data window. The pointer combines an 11-bit byte offset with two flags. One flag chooses which page is used: the page at the head of the receive queue, or the page the host has picked. The other flag turns on auto-increment. The block holds the page RAM (four pages of 2048 bytes by default) and all of the addressing logic. The two page numbers arrive as inputs from the allocation logic that sits next to the block.

Each cycle carries one command: a read or a write, either one byte or two. A two-byte command behaves as two byte accesses in a row, low byte first. The block performs both halves in the same cycle by splitting the RAM into an even bank and an odd bank. Read data comes back one cycle later, together with a valid strobe.

Top module: `pkt_data_port`

## Requirements
- R1: After reset the pointer is zero, `rd_valid` is low and `rd_data` is zero. A read of either pointer byte then returns 0x00.
- R2: Index 0 is the pointer low byte (bits 7:0) and index 1 is the pointer high byte (bits 15:8). Each is written on its own. A read of index 1 returns the high byte ANDed with 0xF7, so pointer bit 11 reads as 0. A two-byte access at register index i covers i and then i+1, with the low data byte going to i.
- R3: Pointer bit 15 chooses the page. When it is 1, the page is `rxq_head_page`. When it is 0, the page is `host_page`. The page input is sampled in the cycle of the access.
- R4: When pointer bit 14 is 0, window index 4+k (k = 0..3) accesses byte offset (bits 10:0 + k) modulo 2048. The pointer does not change.
- R5: When pointer bit 14 is 1, every window byte access uses the current offset, whatever the window index. The offset then advances by one modulo 2048, and bits 15:11 keep their value.
- R6: A two-byte window access puts its low data byte at the first offset and its high byte at the next offset. With bit 14 at 0 these are offset+k and offset+k+1. With bit 14 at 1 they are offset and offset+1, and the pointer advances by two. Read data returns the first byte in bits 7:0 and the second in bits 15:8.
- R7: A read accepted in cycle t raises `rd_valid` for exactly cycle t+1 and carries its data then. A one-byte read puts its data in bits 7:0 with bits 15:8 at zero. When `rd_valid` is low, `rd_data` is zero.
- R8: Indices 2 and 3 read as 0x00, and writes to them change nothing. A cycle that has both `bus_wr` and `bus_rd` high is a write only, and produces no read data.
- R9: An offset that advances or is added past 2047 wraps to 0 within the same page.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_idx | input | 3 | Register index: 0/1 pointer bytes, 2/3 reserved, 4..7 window bytes |
| bus_wr | input | 1 | Write command |
| bus_rd | input | 1 | Read command |
| bus_wide | input | 1 | Two-byte access, low byte first |
| bus_wdata | input | 16 | Write data, low byte for the first access |
| host_page | input | PG_W | Page chosen by the host |
| rxq_head_page | input | PG_W | Page at the head of the receive queue |
| rd_valid | output | 1 | Read data strobe, one cycle after the read |
| rd_data | output | 16 | Read data |

## Verification
Two pointer effects can land in a single cycle. A window access reads or writes the RAM at the current offset, and the same clock edge moves the offset forward. When two lanes fire together, the even bank and the odd bank are both used on one edge. The bench provokes these cases with two-byte writes and reads at offset 2047 in auto-increment mode, where the lanes straddle the wrap to 0. It also issues reads on consecutive cycles, so that returning data meets the next command. Each cycle's `rd_valid`/`rd_data` is judged against a behavioural model. The pointer is read back through the interface to confirm that the flags were kept and that the offset moved by the expected step.

// File: rtl/pdp_pkg.sv
package pdp_pkg;
  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} op_e;
  localparam int          PTR_PAGE_BIT   = 15;
  localparam int          PTR_AUTO_BIT   = 14;
  localparam int          IDX_WIN_BIT    = 2;
  localparam logic [2:0]  IDX_PTR_LO     = 3'd0;
  localparam logic [2:0]  IDX_PTR_HI     = 3'd1;
  localparam logic [7:0]  PTR_HI_RD_MASK = 8'hF7;
endpackage

// File: rtl/pdp_pointer.sv
module pdp_pointer #(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       lo_val,
  input  logic [7:0]       hi_val,
  input  logic             advance,
  input  logic             wide,
  input  logic [1:0]       win_k,
  output logic [15:0]      ptr,
  output logic [OFF_W-1:0] off0,
  output logic [OFF_W-1:0] off1
);
  import pdp_pkg::*;

  logic [15:0]      ptr_q;
  logic [OFF_W-1:0] base;
  logic             auto_inc;

  assign auto_inc = ptr_q[PTR_AUTO_BIT];
  assign base     = ptr_q[OFF_W-1:0];
  assign off0     = auto_inc ? base : base + {{(OFF_W-2){1'b0}}, win_k};
  assign off1     = off0 + OFF_W'(1);
  assign ptr      = ptr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q <= '0;
    end else begin
      if (wr_lo) ptr_q[7:0]  <= lo_val;
      if (wr_hi) ptr_q[15:8] <= hi_val;
      if (advance && auto_inc)
        ptr_q[OFF_W-1:0] <= base + (wide ? OFF_W'(2) : OFF_W'(1));
    end
  end
endmodule

// File: rtl/pdp_page_ram.sv
module pdp_page_ram #(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 2048,
  localparam int PG_W  = $clog2(NUM_PAGES),
  localparam int OFF_W = $clog2(PAGE_BYTES),
  localparam int ROW_W = OFF_W - 1,
  localparam int ROWS  = NUM_PAGES * PAGE_BYTES / 2
) (
  input  logic             clk,
  input  logic             re,
  input  logic             we,
  input  logic             wide,
  input  logic [PG_W-1:0]  page,
  input  logic [OFF_W-1:0] off0,
  input  logic [OFF_W-1:0] off1,
  input  logic [7:0]       wd0,
  input  logic [7:0]       wd1,
  output logic [7:0]       rd0,
  output logic [7:0]       rd1
);
  logic lane0_odd;
  logic lane0_odd_q;

  assign lane0_odd = off0[0];

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [7:0]            mem [ROWS];
    logic [PG_W+ROW_W-1:0] addr;
    logic [7:0]            wd;
    logic                  from_lane0;
    logic                  bank_we;
    logic [7:0]            q;

    assign from_lane0 = (b == 0) ? !lane0_odd : lane0_odd;
    assign addr       = {page, from_lane0 ? off0[OFF_W-1:1] : off1[OFF_W-1:1]};
    assign wd         = from_lane0 ? wd0 : wd1;
    assign bank_we    = we && (from_lane0 || wide);

    always_ff @(posedge clk) begin
      if (bank_we) mem[addr] <= wd;
      if (re)      q <= mem[addr];
    end
  end

  always_ff @(posedge clk) begin
    if (re) lane0_odd_q <= lane0_odd;
  end

  assign rd0 = lane0_odd_q ? g_bank[1].q : g_bank[0].q;
  assign rd1 = lane0_odd_q ? g_bank[0].q : g_bank[1].q;
endmodule

// File: rtl/pdp_rd_fmt.sv
module pdp_rd_fmt (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_req,
  input  logic        is_win,
  input  logic        wide,
  input  logic [15:0] reg_rdata,
  input  logic [7:0]  ram_rd0,
  input  logic [7:0]  ram_rd1,
  output logic        rd_valid,
  output logic [15:0] rd_data
);
  logic        valid_q;
  logic        win_q;
  logic        wide_q;
  logic [15:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      win_q   <= 1'b0;
      wide_q  <= 1'b0;
      reg_q   <= '0;
    end else begin
      valid_q <= rd_req;
      if (rd_req) begin
        win_q  <= is_win;
        wide_q <= wide;
        reg_q  <= reg_rdata;
      end
    end
  end

  always_comb begin
    if (!valid_q)   rd_data = '0;
    else if (win_q) rd_data = {wide_q ? ram_rd1 : 8'h00, ram_rd0};
    else            rd_data = reg_q;
  end

  assign rd_valid = valid_q;
endmodule

// File: rtl/pkt_data_port.sv
module pkt_data_port
  import pdp_pkg::*;
#(
  parameter int NUM_PAGES  = 4,
  parameter int PAGE_BYTES = 2048,
  localparam int PG_W  = $clog2(NUM_PAGES),
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      bus_idx,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic            bus_wide,
  input  logic [15:0]     bus_wdata,
  input  logic [PG_W-1:0] host_page,
  input  logic [PG_W-1:0] rxq_head_page,
  output logic            rd_valid,
  output logic [15:0]     rd_data
);
  op_e              op;
  logic             is_win;
  logic             win_acc;
  logic             win_rd;
  logic             win_wr;
  logic             reg_wr;
  logic             any_rd;
  logic [15:0]      ptr;
  logic [OFF_W-1:0] off0;
  logic [OFF_W-1:0] off1;
  logic [PG_W-1:0]  page;
  logic [7:0]       ram_rd0;
  logic [7:0]       ram_rd1;
  logic [15:0]      reg_rdata;

  always_comb begin
    if (bus_wr)      op = OP_WRITE;
    else if (bus_rd) op = OP_READ;
    else             op = OP_IDLE;
  end

  assign is_win  = bus_idx[IDX_WIN_BIT];
  assign win_acc = is_win && (op != OP_IDLE);
  assign win_rd  = is_win && (op == OP_READ);
  assign win_wr  = is_win && (op == OP_WRITE);
  assign reg_wr  = !is_win && (op == OP_WRITE);
  assign any_rd  = (op == OP_READ);

  pdp_pointer #(.OFF_W(OFF_W)) u_ptr (
    .clk     (clk),
    .rst     (rst),
    .wr_lo   (reg_wr && bus_idx == IDX_PTR_LO),
    .wr_hi   (reg_wr && (bus_idx == IDX_PTR_HI || (bus_wide && bus_idx == IDX_PTR_LO))),
    .lo_val  (bus_wdata[7:0]),
    .hi_val  ((bus_idx == IDX_PTR_LO) ? bus_wdata[15:8] : bus_wdata[7:0]),
    .advance (win_acc),
    .wide    (bus_wide),
    .win_k   (bus_idx[1:0]),
    .ptr     (ptr),
    .off0    (off0),
    .off1    (off1)
  );

  assign page = ptr[PTR_PAGE_BIT] ? rxq_head_page : host_page;

  pdp_page_ram #(.NUM_PAGES(NUM_PAGES), .PAGE_BYTES(PAGE_BYTES)) u_ram (
    .clk  (clk),
    .re   (win_rd),
    .we   (win_wr),
    .wide (bus_wide),
    .page (page),
    .off0 (off0),
    .off1 (off1),
    .wd0  (bus_wdata[7:0]),
    .wd1  (bus_wdata[15:8]),
    .rd0  (ram_rd0),
    .rd1  (ram_rd1)
  );

  function automatic logic [7:0] reg_byte(input logic [2:0] i, input logic [15:0] p);
    if (i == IDX_PTR_LO)      return p[7:0];
    else if (i == IDX_PTR_HI) return p[15:8] & PTR_HI_RD_MASK;
    else                      return 8'h00;
  endfunction

  assign reg_rdata = {bus_wide ? reg_byte(bus_idx + 3'd1, ptr) : 8'h00,
                      reg_byte(bus_idx, ptr)};

  pdp_rd_fmt u_fmt (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (any_rd),
    .is_win    (is_win),
    .wide      (bus_wide),
    .reg_rdata (reg_rdata),
    .ram_rd0   (ram_rd0),
    .ram_rd1   (ram_rd1),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/pkt_data_port_chk.sv
module pkt_data_port_chk #(
  parameter int OFF_W = 11
) (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  bus_idx,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic        bus_wide,
  input logic [15:0] ptr,
  input logic        rd_valid,
  input logic [15:0] rd_data
);
  // R7: a read command yields a valid strobe on the next cycle
  p_valid_after_read_r7: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr) |=> rd_valid);

  // R7 and R8: no strobe without a read-only command
  p_no_stray_valid_r7: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && !bus_wr) |=> !rd_valid);

  // R2: single high pointer byte read never shows bit 11
  p_hi_mask_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_wr && !bus_wide && bus_idx == 3'd1)
      |=> (rd_data[3] == 1'b0 && rd_data[15:8] == 8'h00));

  // R4: aliasing window access keeps the pointer
  p_alias_hold_r4: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && bus_idx[2] && !ptr[14]) |=> $stable(ptr));

  // R5 and R9: auto-increment step keeps the flags and wraps the offset
  p_auto_step_r5: assert property (@(posedge clk) disable iff (rst)
    ((bus_wr || bus_rd) && bus_idx[2] && ptr[14])
      |=> (ptr[15:OFF_W] == $past(ptr[15:OFF_W]) &&
           ptr[OFF_W-1:0] == OFF_W'($past(ptr[OFF_W-1:0]) + ($past(bus_wide) ? 2 : 1))));

  // R8: writes to reserved indices leave the pointer alone
  p_reserved_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_idx[2] && bus_idx[1]) |=> $stable(ptr));
endmodule

bind pkt_data_port pkt_data_port_chk #(.OFF_W(OFF_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_idx  (bus_idx),
  .bus_wr   (bus_wr),
  .bus_rd   (bus_rd),
  .bus_wide (bus_wide),
  .ptr      (ptr),
  .rd_valid (rd_valid),
  .rd_data  (rd_data)
);

// File: tb/sim_pkt_data_port.sv
`timescale 1ns/100ps
module sim_pkt_data_port;
  localparam int PB = 2048;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_idx = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_wide = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [1:0]  host_page = '0;
  logic [1:0]  rxq_head_page = '0;
  logic        rd_valid;
  logic [15:0] rd_data;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  byte unsigned mem [int];
  int          mptr = 0;
  int          hp_v = 0;
  int          rx_v = 0;
  logic        exp_valid = 1'b0;
  logic [15:0] exp_data = '0;
  string       exp_tag = "R1";

  pkt_data_port u0 (
    .clk(clk), .rst(rst), .bus_idx(bus_idx), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wide(bus_wide), .bus_wdata(bus_wdata), .host_page(host_page),
    .rxq_head_page(rxq_head_page), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  always #2.5 clk = ~clk;

  function automatic int reg_val(input int i);
    if (i == 0) return mptr & 'hFF;
    if (i == 1) return (mptr >> 8) & 'hF7;
    return 0;
  endfunction

  task automatic compare();
    checks++;
    if (rd_valid !== exp_valid || rd_data !== exp_data) begin
      fails++;
      $display("FAIL %s: actual valid=%0b data=%h expected valid=%0b data=%h",
               exp_tag, rd_valid, rd_data, exp_valid, exp_data);
    end
  endtask

  task automatic step(input bit wr, input bit rd, input int idx, input bit wide,
                      input int wd, input string tag);
    bit is_wr;
    bit is_rd;
    int nd;
    @(negedge clk);
    compare();
    bus_wr = wr; bus_rd = rd; bus_idx = 3'(idx); bus_wide = wide;
    bus_wdata = 16'(wd); host_page = 2'(hp_v); rxq_head_page = 2'(rx_v);
    is_wr = wr;
    is_rd = rd && !wr;
    nd = 0;
    if (idx >= 4 && (is_wr || is_rd)) begin
      int pg = ((mptr >> 15) & 1) ? rx_v : hp_v;
      int o  = mptr & (PB - 1);
      int o0 = ((mptr >> 14) & 1) ? o : (o + idx - 4) % PB;
      int o1 = (o0 + 1) % PB;
      if (is_wr) begin
        mem[pg*PB + o0] = wd & 'hFF;
        if (wide) mem[pg*PB + o1] = (wd >> 8) & 'hFF;
      end else begin
        nd = mem[pg*PB + o0];
        if (wide) nd = nd | (mem[pg*PB + o1] << 8);
      end
      if ((mptr >> 14) & 1) mptr = (mptr & 'hF800) | ((o + (wide ? 2 : 1)) % PB);
    end else if (idx < 4) begin
      if (is_wr) begin
        for (int l = 0; l < (wide ? 2 : 1); l++) begin
          int v = (wd >> (8*l)) & 'hFF;
          if (idx + l == 0) mptr = (mptr & 'hFF00) | v;
          if (idx + l == 1) mptr = (mptr & 'h00FF) | (v << 8);
        end
      end else if (is_rd) begin
        nd = reg_val(idx) | (wide ? (reg_val(idx + 1) << 8) : 0);
      end
    end
    exp_valid = is_rd;
    exp_data  = is_rd ? 16'(nd) : 16'h0;
    exp_tag   = tag;
  endtask

  task automatic wr8(input int idx, input int v, input string t);  step(1, 0, idx, 0, v, t); endtask
  task automatic rd8(input int idx, input string t);               step(0, 1, idx, 0, 0, t); endtask
  task automatic wr16(input int idx, input int v, input string t); step(1, 0, idx, 1, v, t); endtask
  task automatic rd16(input int idx, input string t);              step(0, 1, idx, 1, 0, t); endtask
  task automatic idle(input string t);                             step(0, 0, 0, 0, 0, t); endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    idle("R1");
    rd8(0, "R1"); rd8(1, "R1");
    // R2: byte-wise pointer, high byte read mask
    wr8(0, 'h34, "R2"); wr8(1, 'h0F, "R2");
    rd8(0, "R2"); rd8(1, "R2");
    wr16(0, 'h0A56, "R2"); rd16(0, "R2"); rd16(1, "R2");
    // R4: aliasing window, pointer held
    hp_v = 1;
    wr16(0, 'h0100, "R4");
    for (int k = 0; k < 4; k++) wr8(4 + k, 'h10 + k, "R4");
    for (int k = 0; k < 4; k++) rd8(4 + k, "R4");
    rd16(0, "R4");
    // R3: page selection
    hp_v = 2;
    wr8(4, 'hA5, "R3");
    rx_v = 1;
    wr8(1, 'h81, "R3");
    rd8(4, "R3");
    hp_v = 3;
    rd8(4, "R3");
    rx_v = 2;
    rd8(4, "R3");
    // R5 and R9: auto-increment across the page end
    wr8(1, 'h47, "R5"); wr8(0, 'hFE, "R5");
    for (int k = 0; k < 4; k++) wr8(6, 'h60 + k, "R9");
    rd16(0, "R5");
    wr16(0, 'h47FE, "R9");
    for (int k = 0; k < 4; k++) rd8(5, "R9");
    rd16(0, "R9");
    wr16(0, 'h07FF, "R9");
    rd8(4, "R9"); rd8(5, "R9"); rd8(7, "R9");
    // R5: flags kept
    rx_v = 0;
    wr16(0, 'hE010, "R5");
    wr8(4, 'h71, "R5"); wr8(5, 'h72, "R5"); wr8(7, 'h73, "R5");
    rd16(0, "R5");
    wr16(0, 'hE010, "R5");
    rd8(4, "R5"); rd8(4, "R5"); rd8(4, "R5");
    // R6: two-byte window accesses
    hp_v = 0;
    wr16(0, 'h0200, "R6");
    wr16(5, 'hBBAA, "R6");
    rd16(5, "R6"); rd8(6, "R6");
    wr16(7, 'hDDCC, "R6");
    rd16(7, "R6");
    wr16(0, 'h47FF, "R6");
    wr16(4, 'h2211, "R6");
    rd16(0, "R6");
    wr16(0, 'h47FF, "R6");
    rd16(4, "R6"); rd16(0, "R6");
    // R8: reserved indices and write priority
    wr8(2, 'hFF, "R8"); wr8(3, 'hFF, "R8");
    rd8(2, "R8"); rd8(3, "R8"); rd16(2, "R8"); rd16(0, "R8");
    step(1, 1, 0, 0, 'h55, "R8");
    rd8(0, "R8");
    // R7: back-to-back reads and idle gaps
    wr16(0, 'h0200, "R7");
    rd8(5, "R7"); rd8(6, "R7"); idle("R7"); rd16(1, "R7");
    idle("R7"); idle("R7");
    finish_run();
  end
endmodule